// File: doc/BRIEF.md
# Serial configuration port with double-buffered register bank

This block is a serial-peripheral slave that gives a host access to a small register bank. A transaction opens with a 16-bit instruction word and continues with one, two or three data bytes, or with as many bytes as the host clocks before it ends the transaction. The register address moves on by one after every byte. Which way it moves depends on the bit order selected in the port's own configuration byte. A most-significant-first port counts the address down, and a least-significant-first port counts it up.

Part of the bank is double buffered. A serial write changes only a staging copy. The copies that drive the downstream logic (`active_o`) take all the staged values together, in the clock cycle after `io_update_i` is sampled high. A select bit picks which copy a serial read returns. The configuration byte also picks the output pin for read data: either the shared data pin, which turns around during a read, or a dedicated output pin. The same byte holds a self-clearing soft reset. Two free bytes hold a 16-bit user tag.

All serial inputs are brought into the `clk_i` domain through synchronizers. `clk_i` must run at least six times faster than the serial clock.

Top module: `spi_cfg_port`

## Requirements
- R1: After `rst_ni` is low, `active_o` is all zeros, both output enables are low, and every register reads back 0x00.
- R2: The instruction word is bit 15 = direction (1 read, 0 write), bits 14:13 = byte count, bits 12:0 = start address. Data bytes follow it directly. Input bits are sampled on the rising serial-clock edge.
- R3: Byte count codes 00, 01 and 10 move 1, 2 and 3 bytes. Any bytes after that are not written, and the output driver stays off during them. Code 11 streams bytes until chip select rises.
- R4: With configuration bit 6 (register 0x000) at 0, the instruction and data travel most significant bit first and the address decrements after each byte. With it at 1, they travel least significant bit first and the address increments. The address wraps within 13 bits.
- R5: With configuration bit 7 at 0, read data leaves on `sdio_o` with `sdio_oe_o` high and `sdo_oe_o` low. With it at 1, read data leaves on `sdo_o` with `sdo_oe_o` high and `sdio_oe_o` low. The two enables are never high together, and both are low while `cs_ni` is high.
- R6: A change written to configuration bits 7 or 6 first applies to the transaction that follows, never to the rest of the current one.
- R7: Register 0x000 reads back as {b7, b6, 0, 0, 0, 0, b6, b7}. The soft-reset bit (bit 5) and the reserved bit 4 always read 0.
- R8: Writing a 1 to bit 5 of register 0x000 returns every register to its reset value. This covers the configuration, the readback select, the user tag, and both the staged and active copies. It also returns the port to most-significant-first, shared-pin mode.
- R9: Writes to the staged registers at addresses BUF_BASE to BUF_BASE+NUM_BUF-1 leave `active_o` unchanged. In the cycle after `io_update_i` is high, every active copy takes its staged value together. Byte i of `active_o` (bits 8i+7:8i) is register BUF_BASE+i.
- R10: Bit 0 of register 0x004 selects what a read of a staged register returns: 0 gives the active copy, and 1 gives the staged copy.
- R11: Registers 0x005 (low byte) and 0x006 (high byte) hold a 16-bit user tag that can be written and read back. Both reset to 0x00, and they affect nothing else.
- R12: Reads from addresses with no register return 0x00, and writes to them change nothing.
- R13: Read data changes only after a falling serial-clock edge and stays stable while the clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from the host |
| cs_ni | input | 1 | Chip select, active low |
| sdio_i | input | 1 | Shared data pin, input side |
| sdio_o | output | 1 | Shared data pin, output side |
| sdio_oe_o | output | 1 | Output enable for the shared data pin |
| sdo_o | output | 1 | Dedicated read-data pin |
| sdo_oe_o | output | 1 | Output enable for the dedicated pin |
| io_update_i | input | 1 | Copies all staged values to the active copies |
| active_o | output | 8*NUM_BUF | Active register copies, byte i = register BUF_BASE+i |

## Verification
The hardest situation to reach is a write that changes the bit order partway through a streaming transaction. If that change took effect at once, it would go unnoticed unless a later byte of the same transfer landed somewhere observable. The stimulus streams in least-significant-first order from address 0x000. The first byte selects most-significant-first, and the stream then walks up to the readback select and the user tag. A follow-up read of the tag proves that the increment direction and the bit order held for the whole transfer. A second hard case is soft reset. The bench first loads non-zero active values and selects the dedicated output pin, so that the reset's effect on each of them can be seen in the next transaction.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int unsigned INSTR_W = 16;
  localparam int unsigned BYTE_W  = 8;

  localparam int unsigned ADDR_CFG   = 0;
  localparam int unsigned ADDR_RBSEL = 4;
  localparam int unsigned ADDR_TAGLO = 5;
  localparam int unsigned ADDR_TAGHI = 6;

  localparam int unsigned CFG_PIN_BIT  = 7;
  localparam int unsigned CFG_ORD_BIT  = 6;
  localparam int unsigned CFG_SRST_BIT = 5;
  localparam int unsigned RBSEL_BIT    = 0;

  typedef enum logic [1:0] {
    PH_INSTR = 2'd0,
    PH_DATA  = 2'd1,
    PH_DONE  = 2'd2
  } phase_e;

  function automatic logic [BYTE_W-1:0] rev_byte(input logic [BYTE_W-1:0] v);
    logic [BYTE_W-1:0] r;
    for (int i = 0; i < BYTE_W; i++) r[i] = v[BYTE_W-1-i];
    return r;
  endfunction

  function automatic logic [INSTR_W-1:0] rev_word(input logic [INSTR_W-1:0] v);
    logic [INSTR_W-1:0] r;
    for (int i = 0; i < INSTR_W; i++) r[i] = v[INSTR_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= RST_VAL;
        else         ff_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/spi_cfg_engine.sv
module spi_cfg_engine
  import spi_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_s_i,
  input  logic              cs_s_i,
  input  logic              sdi_s_i,
  input  logic              cfg_lsb_i,
  input  logic              cfg_pin_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              out_o,
  output logic              fall_o,
  output logic              sdio_oe_o,
  output logic              sdo_oe_o
);
  localparam int unsigned CNT_W = $clog2(INSTR_W);
  localparam int unsigned BIT_W = $clog2(BYTE_W);

  logic              sclk_d, cs_d;
  logic              rise, fall, cs_fall;
  phase_e            phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [INSTR_W-2:0] sh_q;
  logic              lsb_q, pin_q, rd_q, stream_q;
  logic [1:0]        remain_q;
  logic [ADDR_W-1:0] addr_q;
  logic              out_q, oe_q;
  logic [INSTR_W-1:0] word_raw, word;
  logic [BYTE_W-1:0] byte_raw, byte_val;
  logic [BIT_W-1:0]  bit_idx;

  assign rise    = sclk_s_i & ~sclk_d & ~cs_s_i;
  assign fall    = ~sclk_s_i & sclk_d & ~cs_s_i;
  assign cs_fall = ~cs_s_i & cs_d;

  assign word_raw = {sh_q, sdi_s_i};
  assign word     = lsb_q ? rev_word(word_raw) : word_raw;
  assign byte_raw = {sh_q[BYTE_W-2:0], sdi_s_i};
  assign byte_val = lsb_q ? rev_byte(byte_raw) : byte_raw;
  assign bit_idx  = lsb_q ? cnt_q[BIT_W-1:0] : BIT_W'(BYTE_W-1) - cnt_q[BIT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d    <= 1'b0;
      cs_d      <= 1'b1;
      phase_q   <= PH_INSTR;
      cnt_q     <= '0;
      sh_q      <= '0;
      lsb_q     <= 1'b0;
      pin_q     <= 1'b0;
      rd_q      <= 1'b0;
      stream_q  <= 1'b0;
      remain_q  <= '0;
      addr_q    <= '0;
      out_q     <= 1'b0;
      oe_q      <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      sclk_d  <= sclk_s_i;
      cs_d    <= cs_s_i;
      wr_en_o <= 1'b0;
      if (cs_s_i) begin
        phase_q <= PH_INSTR;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else if (cs_fall) begin
        // mode is frozen for the whole transaction
        lsb_q   <= cfg_lsb_i;
        pin_q   <= cfg_pin_i;
        phase_q <= PH_INSTR;
        cnt_q   <= '0;
      end else if (rise) begin
        sh_q <= word_raw[INSTR_W-2:0];
        unique case (phase_q)
          PH_INSTR: begin
            if (cnt_q == CNT_W'(INSTR_W-1)) begin
              rd_q     <= word[INSTR_W-1];
              remain_q <= word[INSTR_W-2 -: 2];
              stream_q <= &word[INSTR_W-2 -: 2];
              addr_q   <= word[ADDR_W-1:0];
              phase_q  <= PH_DATA;
              cnt_q    <= '0;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          PH_DATA: begin
            if (cnt_q[BIT_W-1:0] == BIT_W'(BYTE_W-1)) begin
              if (!rd_q) begin
                wr_en_o   <= 1'b1;
                wr_addr_o <= addr_q;
                wr_data_o <= byte_val;
              end
              addr_q <= lsb_q ? addr_q + ADDR_W'(1) : addr_q - ADDR_W'(1);
              cnt_q  <= '0;
              if (!stream_q) begin
                if (remain_q == 2'd0) phase_q <= PH_DONE;
                else                  remain_q <= remain_q - 2'd1;
              end
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          default: ;
        endcase
      end else if (fall) begin
        if (phase_q == PH_DATA && rd_q) begin
          out_q <= rd_data_i[bit_idx];
          oe_q  <= 1'b1;
        end else begin
          oe_q  <= 1'b0;
        end
      end
    end
  end

  assign rd_addr_o = addr_q;
  assign out_o     = out_q;
  assign fall_o    = fall;
  assign sdio_oe_o = oe_q & ~pin_q;
  assign sdo_oe_o  = oe_q & pin_q;
endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
  import spi_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 13,
  parameter int unsigned NUM_BUF  = 4,
  parameter int unsigned BUF_BASE = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [BYTE_W-1:0]        wr_data_i,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic [BYTE_W-1:0]        rd_data_o,
  input  logic                     io_update_i,
  output logic                     cfg_lsb_o,
  output logic                     cfg_pin_o,
  output logic                     soft_rst_o,
  output logic [BYTE_W*NUM_BUF-1:0] active_o
);
  logic              pin_q, lsb_q, rbsel_q;
  logic [BYTE_W-1:0] tag_lo_q, tag_hi_q;
  logic [BYTE_W-1:0] stage_q [NUM_BUF];
  logic [BYTE_W-1:0] act_q   [NUM_BUF];
  logic              hit_cfg, hit_rb, hit_lo, hit_hi;

  assign hit_cfg    = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_CFG));
  assign hit_rb     = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_RBSEL));
  assign hit_lo     = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_TAGLO));
  assign hit_hi     = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_TAGHI));
  assign soft_rst_o = hit_cfg && wr_data_i[CFG_SRST_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q    <= 1'b0;
      lsb_q    <= 1'b0;
      rbsel_q  <= 1'b0;
      tag_lo_q <= '0;
      tag_hi_q <= '0;
    end else if (soft_rst_o) begin
      pin_q    <= 1'b0;
      lsb_q    <= 1'b0;
      rbsel_q  <= 1'b0;
      tag_lo_q <= '0;
      tag_hi_q <= '0;
    end else begin
      if (hit_cfg) begin
        pin_q <= wr_data_i[CFG_PIN_BIT];
        lsb_q <= wr_data_i[CFG_ORD_BIT];
      end
      if (hit_rb) rbsel_q  <= wr_data_i[RBSEL_BIT];
      if (hit_lo) tag_lo_q <= wr_data_i;
      if (hit_hi) tag_hi_q <= wr_data_i;
    end
  end

  generate
    for (genvar i = 0; i < NUM_BUF; i++) begin : g_buf
      logic hit_stage;
      assign hit_stage = wr_en_i && (wr_addr_i == ADDR_W'(BUF_BASE + i));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          stage_q[i] <= '0;
          act_q[i]   <= '0;
        end else if (soft_rst_o) begin
          stage_q[i] <= '0;
          act_q[i]   <= '0;
        end else begin
          if (hit_stage)   stage_q[i] <= wr_data_i;
          if (io_update_i) act_q[i]   <= stage_q[i];
        end
      end
      assign active_o[BYTE_W*i +: BYTE_W] = act_q[i];
    end
  endgenerate

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == ADDR_W'(ADDR_CFG))
      rd_data_o = {pin_q, lsb_q, 4'b0000, lsb_q, pin_q};
    else if (rd_addr_i == ADDR_W'(ADDR_RBSEL))
      rd_data_o = {{(BYTE_W-1){1'b0}}, rbsel_q};
    else if (rd_addr_i == ADDR_W'(ADDR_TAGLO))
      rd_data_o = tag_lo_q;
    else if (rd_addr_i == ADDR_W'(ADDR_TAGHI))
      rd_data_o = tag_hi_q;
    else
      for (int i = 0; i < NUM_BUF; i++)
        if (rd_addr_i == ADDR_W'(BUF_BASE + i))
          rd_data_o = rbsel_q ? stage_q[i] : act_q[i];
  end

  assign cfg_lsb_o = lsb_q;
  assign cfg_pin_o = pin_q;
endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port
  import spi_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W      = 13,
  parameter int unsigned NUM_BUF     = 4,
  parameter int unsigned BUF_BASE    = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      sclk_i,
  input  logic                      cs_ni,
  input  logic                      sdio_i,
  output logic                      sdio_o,
  output logic                      sdio_oe_o,
  output logic                      sdo_o,
  output logic                      sdo_oe_o,
  input  logic                      io_update_i,
  output logic [BYTE_W*NUM_BUF-1:0] active_o
);
  logic              sclk_s, cs_s, sdi_s;
  logic              cfg_lsb, cfg_pin, soft_rst;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [BYTE_W-1:0] wr_data, rd_data;
  logic              eng_out, eng_fall, eng_sdio_oe, eng_sdo_oe;

  spi_cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sclk_i), .q_o(sclk_s));
  spi_cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cs_ni), .q_o(cs_s));
  spi_cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sdio_i), .q_o(sdi_s));

  spi_cfg_engine #(.ADDR_W(ADDR_W)) u_engine (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sclk_s_i  (sclk_s),
    .cs_s_i    (cs_s),
    .sdi_s_i   (sdi_s),
    .cfg_lsb_i (cfg_lsb),
    .cfg_pin_i (cfg_pin),
    .rd_data_i (rd_data),
    .rd_addr_o (rd_addr),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .out_o     (eng_out),
    .fall_o    (eng_fall),
    .sdio_oe_o (eng_sdio_oe),
    .sdo_oe_o  (eng_sdo_oe)
  );

  spi_cfg_regs #(.ADDR_W(ADDR_W), .NUM_BUF(NUM_BUF), .BUF_BASE(BUF_BASE)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .rd_addr_i   (rd_addr),
    .rd_data_o   (rd_data),
    .io_update_i (io_update_i),
    .cfg_lsb_o   (cfg_lsb),
    .cfg_pin_o   (cfg_pin),
    .soft_rst_o  (soft_rst),
    .active_o    (active_o)
  );

  // driver released at once on raw chip select, without sync delay
  assign sdio_o    = eng_out;
  assign sdo_o     = eng_out;
  assign sdio_oe_o = eng_sdio_oe & ~cs_ni;
  assign sdo_oe_o  = eng_sdo_oe & ~cs_ni;
endmodule

// File: rtl/spi_cfg_port_chk.sv
module spi_cfg_port_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sdio_oe_o,
  input logic             sdo_oe_o,
  input logic             io_update_i,
  input logic             soft_rst,
  input logic             eng_fall,
  input logic             eng_out,
  input logic [WIDTH-1:0] active_o
);
  assert_oe_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sdio_oe_o && sdo_oe_o));

  assert_act_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!io_update_i && !soft_rst) |=> $stable(active_o));

  assert_srst_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (active_o == '0));

  assert_launch_fall_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eng_fall |=> $stable(eng_out));
endmodule

bind spi_cfg_port spi_cfg_port_chk #(.WIDTH(8*NUM_BUF)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sdio_oe_o   (sdio_oe_o),
  .sdo_oe_o    (sdo_oe_o),
  .io_update_i (io_update_i),
  .soft_rst    (soft_rst),
  .eng_fall    (eng_fall),
  .eng_out     (eng_out),
  .active_o    (active_o)
);

// File: tb/sim_spi_cfg_port.sv
module sim_spi_cfg_port;
  localparam int CLK_P    = 10;
  localparam int HB       = 10;
  localparam int NUM_BUF  = 4;
  localparam int BUF_BASE = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, sdio_in = 1'b0, io_upd = 1'b0;
  logic sdio_out, sdio_oe, sdo_out, sdo_oe;
  logic [8*NUM_BUF-1:0] active;

  spi_cfg_port #(.NUM_BUF(NUM_BUF), .BUF_BASE(BUF_BASE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .sdio_i(sdio_in),
    .sdio_o(sdio_out), .sdio_oe_o(sdio_oe), .sdo_o(sdo_out), .sdo_oe_o(sdo_oe),
    .io_update_i(io_upd), .active_o(active));

  always #(CLK_P/2) clk = ~clk;

  int  n_vec = 0, n_err = 0;
  bit  cmp_en = 1'b0, done = 1'b0;
  logic       m_pin, m_lsb, m_rb;
  logic [7:0] m_lo, m_hi;
  logic [7:0] m_stage [NUM_BUF];
  logic [7:0] m_act   [NUM_BUF];

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic m_reset();
    m_pin = 0; m_lsb = 0; m_rb = 0; m_lo = 0; m_hi = 0;
    for (int i = 0; i < NUM_BUF; i++) begin m_stage[i] = 0; m_act[i] = 0; end
  endtask

  function automatic logic [7:0] m_rd(input int a);
    if (a == 0) return {m_pin, m_lsb, 4'b0, m_lsb, m_pin};
    if (a == 4) return {7'b0, m_rb};
    if (a == 5) return m_lo;
    if (a == 6) return m_hi;
    if (a >= BUF_BASE && a < BUF_BASE + NUM_BUF)
      return m_rb ? m_stage[a-BUF_BASE] : m_act[a-BUF_BASE];
    return 8'h00;
  endfunction

  task automatic m_wr(input int a, input logic [7:0] d);
    if (a == 0) begin
      if (d[5]) m_reset();
      else begin m_pin = d[7]; m_lsb = d[6]; end
    end else if (a == 4) m_rb = d[0];
    else if (a == 5) m_lo = d;
    else if (a == 6) m_hi = d;
    else if (a >= BUF_BASE && a < BUF_BASE + NUM_BUF) m_stage[a-BUF_BASE] = d;
  endtask

  function automatic logic [31:0] m_act_vec();
    logic [31:0] v = 0;
    for (int i = 0; i < NUM_BUF; i++) v[8*i +: 8] = m_act[i];
    return v;
  endfunction

  // per-clock comparison of active copies and idle enables
  always @(posedge clk) begin
    #(CLK_P/4);
    if (cmp_en && !done) begin
      chk("R9", active, m_act_vec());
      if (cs_n) chk("R5", {sdio_oe, sdo_oe}, 2'b00);
    end
  end

  task automatic one_bit(input logic b, input bit pinm, output logic got, output logic mid,
                         output logic [1:0] oe);
    sdio_in = b;
    repeat (HB/2) @(negedge clk);
    mid = pinm ? sdo_out : sdio_out;
    repeat (HB - HB/2) @(negedge clk);
    got = pinm ? sdo_out : sdio_out;
    oe  = {sdio_oe, sdo_oe};
    sclk = 1'b1;
    repeat (HB) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic xfer(input bit rd, input logic [1:0] cc, input int addr, input int nb,
                      input logic [63:0] wd);
    bit lsbm, pinm;
    logic [15:0] instr;
    logic got, mid;
    logic [1:0] oe;
    logic [7:0] exp;
    int a, lim;
    lsbm = m_lsb; pinm = m_pin; cmp_en = 0;
    instr = {rd, cc, addr[12:0]};
    @(negedge clk); cs_n = 1'b0;
    repeat (HB) @(negedge clk);
    for (int i = 0; i < 16; i++) one_bit(lsbm ? instr[i] : instr[15-i], pinm, got, mid, oe);
    a = addr;
    lim = (cc == 2'b11) ? 1000 : int'(cc) + 1;
    for (int k = 0; k < nb; k++) begin
      exp = m_rd(a);
      for (int j = 0; j < 8; j++) begin
        int idx = lsbm ? j : 7 - j;
        one_bit(wd[8*k + idx], pinm, got, mid, oe);
        if (rd && k < lim) begin
          chk("R2", got, exp[idx]);
          chk("R13", mid, got);
          chk("R5", oe, pinm ? 2'b01 : 2'b10);
        end else if (rd) begin
          chk("R3", oe, 2'b00);
        end
      end
      if (!rd && k < lim) m_wr(a, wd[8*k +: 8]);
      a = lsbm ? ((a + 1) & 'h1fff) : ((a - 1) & 'h1fff);
    end
    repeat (HB) @(negedge clk);
    cs_n = 1'b1;
    repeat (2*HB) @(negedge clk);
    cmp_en = 1;
  endtask

  task automatic wr1(input int a, input logic [7:0] d);
    xfer(0, 2'b00, a, 1, {56'b0, d});
  endtask

  task automatic rd1(input int a);
    xfer(1, 2'b00, a, 1, 64'b0);
  endtask

  task automatic iou();
    @(negedge clk); io_upd = 1'b1;
    for (int i = 0; i < NUM_BUF; i++) m_act[i] = m_stage[i];
    @(negedge clk); io_upd = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_vec++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1", active, 32'h0);
    chk("R1", {sdio_oe, sdo_oe}, 2'b00);
    cmp_en = 1;
    rd1(0); rd1(5); rd1(BUF_BASE);

    // R11, R4: two-byte write decrementing from the tag high byte
    xfer(0, 2'b01, 6, 2, {48'b0, 8'h3C, 8'hA5});
    xfer(1, 2'b01, 6, 2, 64'b0);

    // R9, R10: three staged writes, active copies untouched until update
    xfer(0, 2'b10, BUF_BASE+3, 3, {40'b0, 8'h33, 8'h22, 8'h11});
    rd1(BUF_BASE+2);
    wr1(4, 8'h01);
    xfer(1, 2'b11, BUF_BASE+3, 4, 64'b0);
    chk("R9", active, 32'h0);
    iou();
    chk("R9", active, m_act_vec());
    wr1(4, 8'h00);
    xfer(1, 2'b11, BUF_BASE+3, 4, 64'b0);

    // R3: count code 00 with a second byte clocked
    xfer(0, 2'b00, BUF_BASE+1, 2, {48'b0, 8'h55, 8'h44});
    wr1(4, 8'h01);
    xfer(1, 2'b01, BUF_BASE+1, 2, 64'b0);
    xfer(1, 2'b00, BUF_BASE+1, 2, 64'b0);

    // R12: holes in the map
    wr1(32, 8'hFF); rd1(32); rd1(1); rd1('h1fff);

    // R7, R4: least-significant-first, incrementing
    wr1(0, 8'h42);
    rd1(0);
    xfer(0, 2'b01, BUF_BASE+1, 2, {48'b0, 8'h77, 8'h66});
    xfer(1, 2'b01, BUF_BASE+1, 2, 64'b0);
    // R6: switch back mid-stream; remaining bytes keep old order and direction
    xfer(0, 2'b11, 0, 6, {16'b0, 8'h5A, 8'h01, 24'b0, 8'h00});
    rd1(5);
    chk("R6", {31'b0, m_lsb}, 32'h0);

    // R5: dedicated output pin
    wr1(0, 8'h81);
    rd1(5);
    xfer(1, 2'b01, 6, 2, 64'b0);
    rd1(0);

    // R8: soft reset from a non-default state
    iou();
    chk("R8", active, m_act_vec());
    wr1(0, 8'h24);
    chk("R8", active, 32'h0);
    rd1(0); rd1(5); rd1(6);
    wr1(4, 8'h01);
    xfer(1, 2'b11, BUF_BASE+3, 4, 64'b0);

    repeat (10) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule